// File: doc/BRIEF.md
# DRAM Bank Auto-Precharge Tracker

This block follows the timing of a single DRAM bank from the point of view of a memory controller. Each cycle it sees one command aimed at the bank: idle, activate, or a read or write column access. A column access has a flag that asks for automatic precharge. From this stream the block works out the cycle in which the bank's hidden internal precharge begins. It then works out the cycle in which the bank is idle again. From those it says whether an activate or a column command would be legal in the current cycle.

After a read with auto-precharge, the precharge starts in the later of two cycles. The first is half a burst after the read. The second is the cycle in which the minimum activate-to-precharge time is met. After a write with auto-precharge, the candidate point moves to one cycle plus half a burst after the write, plus the write-recovery time. The same activate-time limit still applies to writes. The precharge lasts the row-precharge time. During it, and while waiting for it to start, the bank accepts nothing.

Commands that break the rules are flagged and otherwise ignored. These are an activate to a bank that is not idle, a column command that lands inside an auto-precharge sequence, and a column command to an idle bank. The flag is sticky and keeps the cause of the first violation until reset. The timing values `BL`, `TRAS`, `TRP` and `TWR` are parameters counted in clock cycles. The defaults are 4, 6, 3 and 2.

The block is a four-state machine:

- **ST_IDLE**: an activate moves the bank to ST_ACTIVE.
- **ST_ACTIVE**: a column command with the flag set moves the bank to ST_AP_PENDING. A column command without the flag keeps the bank in ST_ACTIVE.
- **ST_AP_PENDING**: when the start delay has expired and the activate time is met, the bank moves to ST_PRECHARGING. `precharge_start` is high in that cycle.
- **ST_PRECHARGING**: when the precharge counter expires, the bank returns to ST_IDLE.

Reset, from any state, goes to ST_IDLE.

Top module: `bank_ap_tracker`

## Requirements
- R1: A synchronous active-high reset puts the bank in the idle state. After reset, `bank_idle`=1, `act_allowed`=1, `col_allowed`=0, `precharge_start`=0, `viol_flag`=0 and `viol_cause`=00.
- R2: `cmd_op` encodes the command as 00 none, 01 activate, 10 read and 11 write. An activate in an idle cycle (cycle A) opens the bank. From cycle A+1, `col_allowed`=1, `bank_idle`=0 and `act_allowed`=0.
- R3: A read or write with `cmd_ap`=0 to an open bank leaves the bank open. `col_allowed` stays 1, no precharge starts, and no violation is raised.
- R4: A read with `cmd_ap`=1 in cycle C, after an activate in cycle A, pulses `precharge_start` for exactly one cycle. That cycle is max(C+BL/2, A+TRAS).
- R5: A write with `cmd_ap`=1 in cycle C, after an activate in cycle A, pulses `precharge_start` for exactly one cycle. That cycle is max(C+1+BL/2+TWR, A+TRAS).
- R6: If the precharge started in cycle S, `bank_idle` and `act_allowed` are 0 from cycle S+1 through S+TRP-1. Both return to 1 in cycle S+TRP, when a new activate is legal.
- R7: A read or write during the wait for precharge start, or during the precharge itself, sets `viol_flag` with `viol_cause`=10. The command is otherwise ignored, and the precharge timing does not change.
- R8: An activate to a bank that is not idle sets `viol_flag` with `viol_cause`=01. It is otherwise ignored and does not reopen the bank.
- R9: A read or write to an idle bank sets `viol_flag` with `viol_cause`=11. It is otherwise ignored, and the bank stays idle.
- R10: Once set, `viol_flag` stays 1 and `viol_cause` keeps the cause of the first violation until reset, whatever further violations occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command to the bank this cycle: 00 none, 01 activate, 10 read, 11 write |
| cmd_ap | input | 1 | Auto-precharge request on a read or write |
| bank_idle | output | 1 | Bank is closed and precharged |
| act_allowed | output | 1 | An activate is legal this cycle |
| col_allowed | output | 1 | A read or write is legal this cycle |
| precharge_start | output | 1 | One-cycle pulse in the cycle the internal precharge begins |
| viol_flag | output | 1 | Sticky protocol-violation flag |
| viol_cause | output | 2 | First violation: 01 early activate, 10 column interrupt, 11 column to idle bank |

## Verification
The bench measures the cycle of the precharge pulse and the cycle of the return to idle in two situations. In the first, the column command comes early enough that the activate-time limit governs. In the second, it comes late enough that the burst or write-recovery delay governs. It also covers the tie point where both give the same cycle. A design that took only one of the two limits would start the precharge too early in one of these situations. An off-by-one in the delay counters would shift the pulse or the idle cycle by one.

Commands that land inside the auto-precharge wait or the precharge itself are sent to check that they are flagged and have no effect on timing. A design that accepted them would restart the delay, move the pulse, or leave the bank open. Violations are also stacked to check that the first cause is kept.

// File: rtl/bank_ap_pkg.sv
package bank_ap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_ACTIVE      = 2'd1,
        ST_AP_PENDING  = 2'd2,
        ST_PRECHARGING = 2'd3
    } bank_state_e;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_ACT   = 2'b01,
        OP_READ  = 2'b10,
        OP_WRITE = 2'b11
    } bank_op_e;

    typedef enum logic [1:0] {
        VC_NONE      = 2'b00,
        VC_EARLY_ACT = 2'b01,
        VC_COL_INTR  = 2'b10,
        VC_IDLE_COL  = 2'b11
    } viol_cause_e;

endpackage

// File: rtl/ap_down_timer.sv
module ap_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/ap_ras_counter.sv
module ap_ras_counter #(
    parameter int TRAS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic met
);
    localparam int W = (TRAS > 1) ? $clog2(TRAS + 1) : 1;
    localparam logic [W-1:0] LIMIT = W'(TRAS);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= W'(1);
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign met = (cnt_q == LIMIT);
endmodule

// File: rtl/ap_viol_latch.sv
module ap_viol_latch (
    input  logic       clk,
    input  logic       rst,
    input  logic       raise,
    input  logic [1:0] cause_in,
    output logic       flag,
    output logic [1:0] cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            cause <= 2'b00;
        end else if (raise && !flag) begin
            flag  <= 1'b1;
            cause <= cause_in;
        end
    end
endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
    import bank_ap_pkg::*;
#(
    parameter int BL   = 4,
    parameter int TRAS = 6,
    parameter int TRP  = 3,
    parameter int TWR  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cmd_op,
    input  logic       cmd_ap,
    output logic       bank_idle,
    output logic       act_allowed,
    output logic       col_allowed,
    output logic       precharge_start,
    output logic       viol_flag,
    output logic [1:0] viol_cause
);
    // Delay from column command to earliest precharge start.
    localparam int RD_DLY  = BL / 2;
    localparam int WR_DLY  = 1 + BL / 2 + TWR;
    localparam int DLY_MAX = WR_DLY - 1;
    localparam int DLY_W   = (DLY_MAX > 1) ? $clog2(DLY_MAX + 1) : 1;
    // Precharge state lasts TRP-1 cycles after the start cycle.
    localparam int RP_LOAD = TRP - 2;
    localparam int RP_W    = (RP_LOAD > 1) ? $clog2(RP_LOAD + 1) : 1;

    bank_state_e state_q, state_d;
    bank_op_e    op;
    logic        is_act, is_col, is_write;
    logic        dly_load, dly_zero, rp_load, rp_zero;
    logic        ras_restart, ras_met;
    logic        viol_raise, pc_start;
    logic [DLY_W-1:0] dly_val;
    viol_cause_e viol_code;

    assign op       = bank_op_e'(cmd_op);
    assign is_act   = (op == OP_ACT);
    assign is_write = (op == OP_WRITE);
    assign is_col   = (op == OP_READ) || is_write;

    ap_ras_counter #(.TRAS(TRAS)) u_ras (
        .clk     (clk),
        .rst     (rst),
        .restart (ras_restart),
        .met     (ras_met)
    );

    ap_down_timer #(.W(DLY_W)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .expired  (dly_zero)
    );

    ap_down_timer #(.W(RP_W)) u_rp (
        .clk      (clk),
        .rst      (rst),
        .load     (rp_load),
        .load_val (RP_W'(RP_LOAD)),
        .expired  (rp_zero)
    );

    ap_viol_latch u_viol (
        .clk      (clk),
        .rst      (rst),
        .raise    (viol_raise),
        .cause_in (viol_code),
        .flag     (viol_flag),
        .cause    (viol_cause)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and counter control
    always_comb begin
        state_d     = state_q;
        dly_load    = 1'b0;
        dly_val     = '0;
        rp_load     = 1'b0;
        ras_restart = 1'b0;
        viol_raise  = 1'b0;
        viol_code   = VC_NONE;
        pc_start    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_act) begin
                    state_d     = ST_ACTIVE;
                    ras_restart = 1'b1;
                end else if (is_col) begin
                    viol_raise = 1'b1;
                    viol_code  = VC_IDLE_COL;
                end
            end
            ST_ACTIVE: begin
                if (is_act) begin
                    viol_raise = 1'b1;
                    viol_code  = VC_EARLY_ACT;
                end else if (is_col && cmd_ap) begin
                    state_d  = ST_AP_PENDING;
                    dly_load = 1'b1;
                    dly_val  = is_write ? DLY_W'(WR_DLY - 1) : DLY_W'(RD_DLY - 1);
                end
            end
            ST_AP_PENDING: begin
                if (dly_zero && ras_met) begin
                    state_d  = ST_PRECHARGING;
                    rp_load  = 1'b1;
                    pc_start = 1'b1;
                end
                if (is_act) begin
                    viol_raise = 1'b1;
                    viol_code  = VC_EARLY_ACT;
                end else if (is_col) begin
                    viol_raise = 1'b1;
                    viol_code  = VC_COL_INTR;
                end
            end
            ST_PRECHARGING: begin
                if (rp_zero) begin
                    state_d = ST_IDLE;
                end
                if (is_act) begin
                    viol_raise = 1'b1;
                    viol_code  = VC_EARLY_ACT;
                end else if (is_col) begin
                    viol_raise = 1'b1;
                    viol_code  = VC_COL_INTR;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        bank_idle       = (state_q == ST_IDLE);
        act_allowed     = (state_q == ST_IDLE);
        col_allowed     = (state_q == ST_ACTIVE);
        precharge_start = pc_start;
    end
endmodule

// File: rtl/bank_ap_tracker_chk.sv
module bank_ap_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cmd_op,
    input logic       cmd_ap,
    input logic       bank_idle,
    input logic       act_allowed,
    input logic       col_allowed,
    input logic       precharge_start,
    input logic       viol_flag,
    input logic [1:0] viol_cause
);
    logic c_act, c_col;
    assign c_act = (cmd_op == 2'b01);
    assign c_col = cmd_op[1];

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (bank_idle && !viol_flag && viol_cause == 2'b00));

    a_r2_act_opens: assert property (@(posedge clk) disable iff (rst)
        (bank_idle && c_act) |=> col_allowed);

    a_r3_plain_col_keeps_open: assert property (@(posedge clk) disable iff (rst)
        (col_allowed && c_col && !cmd_ap) |=> col_allowed);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        precharge_start |=> !precharge_start);

    a_r6_not_idle_after_start: assert property (@(posedge clk) disable iff (rst)
        precharge_start |=> !bank_idle);

    a_r6_grants_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(act_allowed && col_allowed));

    a_r7_interrupt_cause: assert property (@(posedge clk) disable iff (rst)
        (!viol_flag && !bank_idle && !col_allowed && c_col)
        |=> (viol_flag && viol_cause == 2'b10));

    a_r8_early_act_cause: assert property (@(posedge clk) disable iff (rst)
        (!viol_flag && !bank_idle && c_act) |=> (viol_flag && viol_cause == 2'b01));

    a_r9_idle_col_cause: assert property (@(posedge clk) disable iff (rst)
        (!viol_flag && bank_idle && c_col) |=> (viol_flag && viol_cause == 2'b11));

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        viol_flag |=> (viol_flag && $stable(viol_cause)));
endmodule

bind bank_ap_tracker bank_ap_tracker_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_op          (cmd_op),
    .cmd_ap          (cmd_ap),
    .bank_idle       (bank_idle),
    .act_allowed     (act_allowed),
    .col_allowed     (col_allowed),
    .precharge_start (precharge_start),
    .viol_flag       (viol_flag),
    .viol_cause      (viol_cause)
);

// File: tb/bank_ap_tracker_tb.sv
`timescale 1ns/1ps
module bank_ap_tracker_tb;
    localparam int BL = 4, TRAS = 6, TRP = 3, TWR = 2;
    localparam int NVEC = 7;
    // {column gap after activate, is write, expected start, expected idle}
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{2, 0,  6,  9},   // read, activate time governs
        '{8, 0, 10, 13},   // read, burst governs
        '{4, 0,  6,  9},   // read, tie
        '{5, 0,  7, 10},   // read, burst governs by one
        '{1, 1,  6,  9},   // write, tie
        '{8, 1, 13, 16},   // write, recovery governs
        '{3, 1,  8, 11}    // write, recovery governs
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_ap = 1'b0;
    logic       bank_idle, act_allowed, col_allowed, precharge_start, viol_flag;
    logic [1:0] viol_cause;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bank_ap_tracker #(.BL(BL), .TRAS(TRAS), .TRP(TRP), .TWR(TWR)) u_dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_ap(cmd_ap),
        .bank_idle(bank_idle), .act_allowed(act_allowed), .col_allowed(col_allowed),
        .precharge_start(precharge_start), .viol_flag(viol_flag), .viol_cause(viol_cause)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cmd_op = 2'b00; cmd_ap = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic [1:0] op, input logic ap);
        @(negedge clk);
        cmd_op = op; cmd_ap = ap;
    endtask

    // Activate in cycle 0, AP column at gap, optional extra command at xk.
    task automatic run_seq(input int gap, input bit wr, input int xk,
                           input logic [1:0] xop, input logic xap,
                           output int s_k, output int i_k, output int pulses);
        s_k = -1; i_k = -1; pulses = 0;
        send(2'b01, 1'b0);
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (precharge_start) begin
                pulses++;
                if (s_k < 0) s_k = k;
            end
            if (bank_idle && s_k >= 0 && i_k < 0) i_k = k;
            if (k == 1) check(col_allowed == 1'b1 && bank_idle == 1'b0, "R2 open after activate", int'(col_allowed), 1);
            if (k == gap) begin
                cmd_op = wr ? 2'b11 : 2'b10; cmd_ap = 1'b1;
            end else if (k == xk) begin
                cmd_op = xop; cmd_ap = xap;
            end else begin
                cmd_op = 2'b00; cmd_ap = 1'b0;
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int s_k, i_k, pulses;

        // R1 reset state
        do_reset();
        @(negedge clk);
        check(bank_idle == 1'b1, "R1 bank_idle", int'(bank_idle), 1);
        check(act_allowed == 1'b1, "R1 act_allowed", int'(act_allowed), 1);
        check(col_allowed == 1'b0, "R1 col_allowed", int'(col_allowed), 0);
        check(precharge_start == 1'b0, "R1 precharge_start", int'(precharge_start), 0);
        check(viol_flag == 1'b0, "R1 viol_flag", int'(viol_flag), 0);
        check(viol_cause == 2'b00, "R1 viol_cause", int'(viol_cause), 0);

        // R4 / R5 / R6 timing table
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            run_seq(VEC[v][0], VEC[v][1] != 0, -1, 2'b00, 1'b0, s_k, i_k, pulses);
            if (VEC[v][1] != 0) begin
                check(s_k == VEC[v][2], "R5 write precharge start cycle", s_k, VEC[v][2]);
                check(pulses == 1, "R5 single pulse", pulses, 1);
            end else begin
                check(s_k == VEC[v][2], "R4 read precharge start cycle", s_k, VEC[v][2]);
                check(pulses == 1, "R4 single pulse", pulses, 1);
            end
            check(i_k == VEC[v][3], "R6 idle cycle", i_k, VEC[v][3]);
            check(act_allowed == 1'b1 && viol_flag == 1'b0, "R6 activate legal after precharge", int'(act_allowed), 1);
        end

        // R3 column commands without auto-precharge
        do_reset();
        send(2'b01, 1'b0);
        for (int k = 0; k < 7; k++) send(2'b00, 1'b0);
        send(2'b10, 1'b0);
        send(2'b11, 1'b0);
        pulses = 0;
        for (int k = 0; k < 20; k++) begin
            send(2'b00, 1'b0);
            if (precharge_start) pulses++;
        end
        check(pulses == 0, "R3 no precharge pulse", pulses, 0);
        check(col_allowed == 1'b1, "R3 bank stays open", int'(col_allowed), 1);
        check(viol_flag == 1'b0, "R3 no violation", int'(viol_flag), 0);

        // R7 column interrupt during wait: timing unchanged
        do_reset();
        run_seq(8, 1'b0, 9, 2'b11, 1'b1, s_k, i_k, pulses);
        check(viol_flag == 1'b1 && viol_cause == 2'b10, "R7 cause", int'(viol_cause), 2);
        check(s_k == 10 && pulses == 1, "R7 start unchanged", s_k, 10);
        check(i_k == 13, "R7 idle unchanged", i_k, 13);

        // R7 column interrupt during precharge
        do_reset();
        run_seq(8, 1'b0, 11, 2'b10, 1'b0, s_k, i_k, pulses);
        check(viol_flag == 1'b1 && viol_cause == 2'b10, "R7 cause in precharge", int'(viol_cause), 2);
        check(i_k == 13, "R7 idle unchanged in precharge", i_k, 13);

        // R8 early activate during precharge is ignored
        do_reset();
        run_seq(8, 1'b0, 11, 2'b01, 1'b0, s_k, i_k, pulses);
        check(viol_flag == 1'b1 && viol_cause == 2'b01, "R8 cause", int'(viol_cause), 1);
        check(i_k == 13, "R8 idle unchanged", i_k, 13);
        check(bank_idle == 1'b1 && col_allowed == 1'b0, "R8 activate not taken", int'(col_allowed), 0);

        // R8 activate to an open bank
        do_reset();
        send(2'b01, 1'b0);
        send(2'b01, 1'b0);
        send(2'b00, 1'b0);
        check(viol_flag == 1'b1 && viol_cause == 2'b01, "R8 activate to open bank", int'(viol_cause), 1);

        // R9 column to idle bank, then R10 stickiness
        do_reset();
        send(2'b10, 1'b1);
        send(2'b00, 1'b0);
        check(viol_flag == 1'b1 && viol_cause == 2'b11, "R9 cause", int'(viol_cause), 3);
        check(bank_idle == 1'b1 && precharge_start == 1'b0, "R9 bank stays idle", int'(bank_idle), 1);
        send(2'b01, 1'b0);
        send(2'b01, 1'b0);
        send(2'b00, 1'b0);
        check(viol_flag == 1'b1 && viol_cause == 2'b11, "R10 first cause kept", int'(viol_cause), 3);
        do_reset();
        @(negedge clk);
        check(viol_flag == 1'b0 && viol_cause == 2'b00, "R1 reset clears violation", int'(viol_flag), 0);

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule